// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear, byte-addressed framebuffer. It takes one command at a time on a valid/ready port. A command is either a solid fill of a rectangle with a colour word, or a block copy from one rectangle to another. The pixel size can be 1 to 4 bytes, and the screen width can be programmed. The engine moves one byte per cycle for fills and one byte every two cycles for copies, through a single read/write framebuffer port whose read data returns one cycle after the request.

When a drawing operation finishes, the rectangle it changed is written into a circular queue of dirty regions. A flush request drains this queue in order to a display-update output, one region per cycle. Each region is clipped to the current screen size on its way out. If a full-screen invalidate is signalled together with the flush, the queued regions are dropped instead, because a full redraw will cover them.

Copies give the same result as a copy through a temporary buffer, even when source and destination overlap. The engine does this by choosing the row order from the vertical positions and the byte order within a row from the horizontal positions.

Top module: `rect_blit_engine`

## Requirements
- R1: A pixel at column x, row y starts at byte address bpp*x + (bpp*cfg_width)*y. cfg_bpp is a count of bytes, 1 to 4.
- R2: A fill (cmd_op = 0) writes the colour word least significant byte first. Its lowest cfg_bpp bytes repeat across each row of the rectangle.
- R3: A copy (cmd_op = 1) whose destination row is below its source row (dst_y > src_y) processes rows from the last row upward. The result equals a copy through a temporary buffer.
- R4: A copy with dst_y <= src_y processes rows from the first row downward. Within a row it works left to right when dst_x <= src_x and right to left otherwise, so overlaps on the same row give a temporary-buffer result. Each byte is read one cycle before it is written.
- R5: A completed fill queues the filled rectangle, and a completed copy queues its destination rectangle. A flush emits the queued rectangles in push order, one per cycle, starting in the cycle after the flush.
- R6: The dirty queue has 512 entries, and its read and write indices wrap modulo 512, so entries pushed across the wrap point drain in order.
- R7: A flush while the invalidate input is high discards every queued rectangle and emits nothing. A later flush emits nothing either.
- R8: An emitted rectangle with x+w > cfg_width leaves with x = min(x, cfg_width) and w = cfg_width - x. The same rule applies to y, h and cfg_height.
- R9: A command of zero width or zero height completes in the cycle it is accepted. It writes no memory and queues no rectangle.
- R10: cmd_ready is high only while the engine is idle. The framebuffer port is not used while the engine is idle.
- R11: After reset the engine is idle with cmd_ready high, no memory access, no update output and an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | 12 | Screen width in pixels |
| cfg_height | input | 12 | Screen height in pixels |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted when valid |
| cmd_op | input | 1 | 0 fill, 1 copy |
| cmd_colour | input | 32 | Fill colour word |
| cmd_src_x | input | 12 | Copy source column |
| cmd_src_y | input | 12 | Copy source row |
| cmd_dst_x | input | 12 | Destination column (fill position) |
| cmd_dst_y | input | 12 | Destination row (fill position) |
| cmd_w | input | 12 | Rectangle width in pixels |
| cmd_h | input | 12 | Rectangle height in rows |
| mem_rd_en | output | 1 | Framebuffer byte read request |
| mem_rd_addr | output | AW | Read byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| mem_wr_en | output | 1 | Framebuffer byte write |
| mem_wr_addr | output | AW | Write byte address |
| mem_wr_data | output | 8 | Write data |
| flush | input | 1 | Drain the dirty queue |
| inval | input | 1 | Full-screen invalidate, sampled with flush |
| upd_valid | output | 1 | Update rectangle present |
| upd_x | output | 12 | Update column, clipped |
| upd_y | output | 12 | Update row, clipped |
| upd_w | output | 12 | Update width, clipped |
| upd_h | output | 12 | Update height, clipped |

## Verification
The assertions assume that cfg_width, cfg_height and cfg_bpp stay constant while a command runs and while the queue drains, that cfg_bpp is between 1 and 4, and that the framebuffer answers a read in exactly one cycle. The stimulus sets the configuration only while the engine is idle and the queue is empty. It keeps every address inside the modelled memory and never pushes more than 511 rectangles between flushes. Otherwise a full wrap would make the queue look empty.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;
  localparam int CW = 12;

  typedef logic [CW-1:0] coord_t;

  typedef struct packed {
    coord_t x;
    coord_t y;
    coord_t w;
    coord_t h;
  } rect_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_CRD,
    ST_CWR,
    ST_PUSH
  } blit_st_e;

  // byte address of pixel (x,y) plus an offset inside its row
  function automatic logic [31:0] byte_addr(input logic [31:0] bpp,
                                            input logic [31:0] width,
                                            input logic [31:0] x,
                                            input logic [31:0] y,
                                            input logic [31:0] off);
    logic [31:0] pitch;
    pitch = bpp * width;
    return bpp * x + pitch * y + off;
  endfunction

  // clamp a rectangle to the screen
  function automatic rect_t clip_rect(input rect_t r, input coord_t sw, input coord_t sh);
    rect_t o;
    o = r;
    if ({1'b0, r.x} + {1'b0, r.w} > {1'b0, sw}) begin
      o.x = (r.x < sw) ? r.x : sw;
      o.w = sw - o.x;
    end
    if ({1'b0, r.y} + {1'b0, r.h} > {1'b0, sh}) begin
      o.y = (r.y < sh) ? r.y : sh;
      o.h = sh - o.y;
    end
    return o;
  endfunction
endpackage

// File: rtl/blit_walker.sv
module blit_walker
  import rect_blit_pkg::*;
#(
  parameter int BW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  coord_t        rows,
  input  logic [BW-1:0] row_bytes,
  input  logic [2:0]    bpp,
  input  logic          up,
  input  logic          rtl,
  output coord_t        row,
  output logic [BW-1:0] boff,
  output logic [1:0]    phase,
  output logic          last
);
  localparam logic [BW-1:0] BONE = BW'(1);
  localparam coord_t        RONE = CW'(1);

  coord_t        r_q;
  logic [BW-1:0] b_q;
  logic [1:0]    ph_q;
  logic          row_end;

  assign row_end = (b_q == row_bytes - BONE);

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      r_q  <= '0;
      b_q  <= '0;
      ph_q <= '0;
    end else if (step) begin
      if (row_end) begin
        b_q  <= '0;
        r_q  <= r_q + RONE;
        ph_q <= '0;
      end else begin
        b_q  <= b_q + BONE;
        ph_q <= ({1'b0, ph_q} == bpp - 3'd1) ? 2'd0 : ph_q + 2'd1;
      end
    end
  end

  assign row   = up  ? (rows - RONE - r_q) : r_q;
  assign boff  = rtl ? (row_bytes - BONE - b_q) : b_q;
  assign phase = ph_q;
  assign last  = row_end && (r_q == rows - RONE);
endmodule

// File: rtl/dirty_rect_queue.sv
module dirty_rect_queue
  import rect_blit_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  rect_t  push_rect,
  input  logic   flush,
  input  logic   inval,
  input  coord_t scr_w,
  input  coord_t scr_h,
  output logic   upd_valid,
  output rect_t  upd_rect
);
  localparam int IW = $clog2(DEPTH);
  localparam logic [IW-1:0] IONE = IW'(1);

  rect_t         slots [DEPTH];
  logic [IW-1:0] wr_q;
  logic [IW-1:0] rd_q;
  logic          draining_q;
  logic          has_entry;

  assign has_entry = (rd_q != wr_q);

  always_ff @(posedge clk) begin
    if (push) slots[wr_q] <= push_rect;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q       <= '0;
      rd_q       <= '0;
      draining_q <= 1'b0;
      upd_valid  <= 1'b0;
      upd_rect   <= '0;
    end else begin
      if (push) wr_q <= wr_q + IONE;
      upd_valid <= 1'b0;
      if (flush && inval) begin
        rd_q       <= wr_q;
        draining_q <= 1'b0;
      end else begin
        if (flush) draining_q <= 1'b1;
        if ((draining_q || flush) && has_entry) begin
          upd_valid <= 1'b1;
          upd_rect  <= clip_rect(slots[rd_q], scr_w, scr_h);
          rd_q      <= rd_q + IONE;
        end else if (draining_q) begin
          draining_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
  import rect_blit_pkg::*;
#(
  parameter int AW     = 16,
  parameter int QDEPTH = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_width,
  input  logic [CW-1:0] cfg_height,
  input  logic [2:0]    cfg_bpp,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [31:0]   cmd_colour,
  input  logic [CW-1:0] cmd_src_x,
  input  logic [CW-1:0] cmd_src_y,
  input  logic [CW-1:0] cmd_dst_x,
  input  logic [CW-1:0] cmd_dst_y,
  input  logic [CW-1:0] cmd_w,
  input  logic [CW-1:0] cmd_h,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [7:0]    mem_wr_data,
  input  logic          flush,
  input  logic          inval,
  output logic          upd_valid,
  output logic [CW-1:0] upd_x,
  output logic [CW-1:0] upd_y,
  output logic [CW-1:0] upd_w,
  output logic [CW-1:0] upd_h
);
  localparam int BW = CW + 2;

  blit_st_e      st_q;
  logic          op_q;
  logic [31:0]   col_q;
  coord_t        sx_q, sy_q, dx_q, dy_q, w_q, h_q;

  logic          accept;
  logic          zero_cmd;
  logic          start;
  logic          step;
  logic          up;
  logic          rtl;
  logic [BW-1:0] row_bytes;
  coord_t        row;
  logic [BW-1:0] boff;
  logic [1:0]    phase;
  logic          last;

  // named events for the checker
  logic          push_evt;
  rect_t         push_rect;
  rect_t         upd_rect;

  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign zero_cmd  = (cmd_w == '0) || (cmd_h == '0);
  assign start     = accept && !zero_cmd;
  assign step      = (st_q == ST_FILL) || (st_q == ST_CWR);
  assign up        = op_q && (dy_q > sy_q);
  assign rtl       = op_q && (dx_q > sx_q);
  assign row_bytes = {{(BW-3){1'b0}}, cfg_bpp} * {2'b00, w_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      op_q  <= 1'b0;
      col_q <= '0;
      sx_q  <= '0;
      sy_q  <= '0;
      dx_q  <= '0;
      dy_q  <= '0;
      w_q   <= '0;
      h_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            op_q  <= cmd_op;
            col_q <= cmd_colour;
            sx_q  <= cmd_src_x;
            sy_q  <= cmd_src_y;
            dx_q  <= cmd_dst_x;
            dy_q  <= cmd_dst_y;
            w_q   <= cmd_w;
            h_q   <= cmd_h;
            if (!zero_cmd) st_q <= cmd_op ? ST_CRD : ST_FILL;
          end
        end
        ST_FILL: if (last) st_q <= ST_PUSH;
        ST_CRD:  st_q <= ST_CWR;
        ST_CWR:  st_q <= last ? ST_PUSH : ST_CRD;
        ST_PUSH: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  blit_walker #(.BW(BW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step      (step),
    .rows      (h_q),
    .row_bytes (row_bytes),
    .bpp       (cfg_bpp),
    .up        (up),
    .rtl       (rtl),
    .row       (row),
    .boff      (boff),
    .phase     (phase),
    .last      (last)
  );

  assign mem_rd_en   = (st_q == ST_CRD);
  assign mem_wr_en   = step;
  assign mem_rd_addr = AW'(byte_addr(32'(cfg_bpp), 32'(cfg_width), 32'(sx_q),
                                     32'(sy_q) + 32'(row), 32'(boff)));
  assign mem_wr_addr = AW'(byte_addr(32'(cfg_bpp), 32'(cfg_width), 32'(dx_q),
                                     32'(dy_q) + 32'(row), 32'(boff)));
  assign mem_wr_data = (st_q == ST_FILL) ? col_q[{phase, 3'b000} +: 8] : mem_rd_data;

  assign push_evt  = (st_q == ST_PUSH);
  assign push_rect = '{x: dx_q, y: dy_q, w: w_q, h: h_q};

  dirty_rect_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .push_rect (push_rect),
    .flush     (flush),
    .inval     (inval),
    .scr_w     (cfg_width),
    .scr_h     (cfg_height),
    .upd_valid (upd_valid),
    .upd_rect  (upd_rect)
  );

  assign upd_x = upd_rect.x;
  assign upd_y = upd_rect.y;
  assign upd_w = upd_rect.w;
  assign upd_h = upd_rect.h;
endmodule

// File: rtl/rect_blit_checker.sv
module rect_blit_checker
  import rect_blit_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   cmd_ready,
  input logic   mem_rd_en,
  input logic   mem_wr_en,
  input logic   flush,
  input logic   inval,
  input logic   upd_valid,
  input coord_t upd_x,
  input coord_t upd_y,
  input coord_t upd_w,
  input coord_t upd_h,
  input coord_t cfg_width,
  input coord_t cfg_height,
  input logic   push_evt,
  input rect_t  push_rect
);
  AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_wr_en && !mem_rd_en)); // R10

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (mem_wr_en && !mem_rd_en)); // R4

  AST_PUSH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (push_rect.w != '0 && push_rect.h != '0)); // R9

  AST_INVAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && inval) |=> !upd_valid); // R7

  AST_CLIP_X: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ({1'b0, upd_x} + {1'b0, upd_w} <= {1'b0, cfg_width})); // R8

  AST_CLIP_Y: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ({1'b0, upd_y} + {1'b0, upd_h} <= {1'b0, cfg_height})); // R8

  AST_PUSH_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> !cmd_ready); // R5
endmodule

bind rect_blit_engine rect_blit_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_ready  (cmd_ready),
  .mem_rd_en  (mem_rd_en),
  .mem_wr_en  (mem_wr_en),
  .flush      (flush),
  .inval      (inval),
  .upd_valid  (upd_valid),
  .upd_x      (upd_x),
  .upd_y      (upd_y),
  .upd_w      (upd_w),
  .upd_h      (upd_h),
  .cfg_width  (cfg_width),
  .cfg_height (cfg_height),
  .push_evt   (push_evt),
  .push_rect  (push_rect)
);

// File: tb/rect_blit_engine_bench.sv
`timescale 1ns/1ps
module rect_blit_engine_bench;
  localparam int AW = 16;
  localparam int SW = 16;
  localparam int SH = 16;
  localparam int MSZ = 2048;

  typedef struct packed {
    logic        op;
    logic [2:0]  bpp;
    logic [7:0]  sx, sy, dx, dy, w, h;
    logic [31:0] col;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd1, 8'd0, 8'd0, 8'd2,  8'd1, 8'd5, 8'd3, 32'h0000_00A5},
    '{1'b0, 3'd3, 8'd0, 8'd0, 8'd1,  8'd2, 8'd4, 8'd2, 32'h0033_2211},
    '{1'b0, 3'd4, 8'd0, 8'd0, 8'd0,  8'd0, 8'd3, 8'd2, 32'hDEAD_BEEF},
    '{1'b0, 3'd2, 8'd0, 8'd0, 8'd3,  8'd4, 8'd6, 8'd1, 32'h0000_ABCD},
    '{1'b1, 3'd2, 8'd1, 8'd1, 8'd2,  8'd3, 8'd5, 8'd4, 32'h0},
    '{1'b1, 3'd2, 8'd2, 8'd4, 8'd1,  8'd2, 8'd5, 8'd4, 32'h0},
    '{1'b1, 3'd1, 8'd2, 8'd5, 8'd5,  8'd5, 8'd7, 8'd2, 32'h0},
    '{1'b1, 3'd4, 8'd6, 8'd6, 8'd3,  8'd6, 8'd5, 8'd3, 32'h0},
    '{1'b1, 3'd3, 8'd0, 8'd0, 8'd8,  8'd9, 8'd4, 8'd3, 32'h0}
  };
  localparam string VREQ [NV] = '{"R1", "R2", "R2", "R1", "R3", "R4", "R4", "R4", "R5"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   cfg_width = 12'(SW), cfg_height = 12'(SH);
  logic [2:0]    cfg_bpp = 3'd1;
  logic          cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
  logic [31:0]   cmd_colour = '0;
  logic [11:0]   cmd_src_x = '0, cmd_src_y = '0, cmd_dst_x = '0, cmd_dst_y = '0, cmd_w = '0, cmd_h = '0;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]    mem_rd_data = '0, mem_wr_data;
  logic          flush = 1'b0, inval = 1'b0;
  logic          upd_valid;
  logic [11:0]   upd_x, upd_y, upd_w, upd_h;

  logic [7:0] fb [MSZ];
  logic [7:0] model [MSZ];
  int got_x [1024], got_y [1024], got_w [1024], got_h [1024];
  int n_got;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  rect_blit_engine #(.AW(AW), .QDEPTH(512)) u_rect_blit_engine (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_bpp(cfg_bpp),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_colour(cmd_colour),
    .cmd_src_x(cmd_src_x), .cmd_src_y(cmd_src_y), .cmd_dst_x(cmd_dst_x), .cmd_dst_y(cmd_dst_y),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .flush(flush), .inval(inval), .upd_valid(upd_valid),
    .upd_x(upd_x), .upd_y(upd_y), .upd_w(upd_w), .upd_h(upd_h)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= fb[mem_rd_addr[10:0]];
    if (mem_wr_en) fb[mem_wr_addr[10:0]] <= mem_wr_data;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL R10 watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < MSZ; i++) begin
      fb[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
  endtask

  // pixel (x,y) offset b: ((y*SW)+x)*bpp + b
  function automatic int px(input int bpp, input int x, input int y, input int b);
    return (y * SW + x) * bpp + b;
  endfunction

  task automatic model_apply(input vec_t v);
    logic [7:0] tmp [1024];
    int bpp = int'(v.bpp);
    for (int r = 0; r < int'(v.h); r++)
      for (int b = 0; b < bpp * int'(v.w); b++)
        if (v.op) tmp[r * 64 + b] = model[px(bpp, v.sx, v.sy + r, b)];
        else      tmp[r * 64 + b] = v.col[8 * (b % bpp) +: 8];
    for (int r = 0; r < int'(v.h); r++)
      for (int b = 0; b < bpp * int'(v.w); b++)
        model[px(bpp, v.dx, v.dy + r, b)] = tmp[r * 64 + b];
  endtask

  task automatic compare_mem(input string req);
    int bad = -1;
    for (int i = MSZ - 1; i >= 0; i--) if (fb[i] !== model[i]) bad = i;
    if (bad < 0) check(1'b1, req, "framebuffer", 0, 0);
    else check(1'b0, req, $sformatf("framebuffer byte %0d", bad), int'(fb[bad]), int'(model[bad]));
  endtask

  task automatic run_cmd(input vec_t v, output bit busy_seen);
    @(negedge clk);
    cfg_bpp = v.bpp; cmd_op = v.op; cmd_colour = v.col;
    cmd_src_x = 12'(v.sx); cmd_src_y = 12'(v.sy); cmd_dst_x = 12'(v.dx); cmd_dst_y = 12'(v.dy);
    cmd_w = 12'(v.w); cmd_h = 12'(v.h); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy_seen = !cmd_ready;
    for (int k = 0; k < 5000 && !cmd_ready; k++) @(negedge clk);
    model_apply(v);
  endtask

  task automatic do_flush(input bit iv);
    int idle = 0;
    @(negedge clk);
    flush = 1'b1; inval = iv;
    @(negedge clk);
    flush = 1'b0; inval = 1'b0;
    n_got = 0;
    while (idle < 3) begin
      if (upd_valid) begin
        got_x[n_got] = int'(upd_x); got_y[n_got] = int'(upd_y);
        got_w[n_got] = int'(upd_w); got_h[n_got] = int'(upd_h);
        n_got = n_got + 1; idle = 0;
      end else idle = idle + 1;
      @(negedge clk);
    end
  endtask

  function automatic vec_t mk_fill(input int bpp, input int x, input int y, input int w, input int h, input logic [31:0] c);
    vec_t v;
    v = '{1'b0, 3'(bpp), 8'd0, 8'd0, 8'(x), 8'(y), 8'(w), 8'(h), c};
    return v;
  endfunction

  task automatic check_rect(input string req, input int i, input int x, input int y, input int w, input int h);
    check(got_x[i] == x && got_y[i] == y && got_w[i] == w && got_h[i] == h, req,
          $sformatf("rect %0d x/y/w/h=%0d/%0d/%0d/%0d", i, got_x[i], got_y[i], got_w[i], got_h[i]),
          got_x[i] * 1000 + got_w[i], x * 1000 + w);
  endtask

  initial begin
    bit bz;
    int bad;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cmd_ready && !upd_valid && !mem_wr_en && !mem_rd_en, "R11", "idle after reset",
          {cmd_ready, upd_valid, mem_wr_en, mem_rd_en}, 4'b1000);
    do_flush(1'b0);
    check(n_got == 0, "R11", "empty queue after reset", n_got, 0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      init_mem();
      run_cmd(VECS[i], bz);
      check(bz, "R10", "ready low while busy", int'(bz), 1);
      compare_mem(VREQ[i]);
      do_flush(1'b0);
      check(n_got == 1, "R5", "one rect queued", n_got, 1);
      check_rect("R5", 0, VECS[i].dx, VECS[i].dy, VECS[i].w, VECS[i].h);
    end

    // R8 clipping
    init_mem();
    run_cmd(mk_fill(1, 14, 2, 5, 1, 32'h77), bz);
    run_cmd(mk_fill(1, 0, 14, 2, 4, 32'h55), bz);
    run_cmd(mk_fill(1, 20, 0, 3, 1, 32'h33), bz);
    compare_mem("R1");
    do_flush(1'b0);
    check(n_got == 3, "R8", "clipped count", n_got, 3);
    check_rect("R8", 0, 14, 2, 2, 1);
    check_rect("R8", 1, 0, 14, 2, 2);
    check_rect("R8", 2, 16, 0, 0, 1);

    // R7 invalidate
    run_cmd(mk_fill(2, 1, 1, 2, 2, 32'h1234), bz);
    run_cmd(mk_fill(2, 3, 3, 2, 2, 32'h5678), bz);
    do_flush(1'b1);
    check(n_got == 0, "R7", "inval flush emits", n_got, 0);
    do_flush(1'b0);
    check(n_got == 0, "R7", "later flush emits", n_got, 0);

    // R9 zero size
    init_mem();
    run_cmd(mk_fill(1, 2, 2, 0, 3, 32'hFF), bz);
    check(!bz, "R9", "zero fill idle at once", int'(bz), 0);
    run_cmd('{1'b1, 3'd2, 8'd0, 8'd0, 8'd4, 8'd4, 8'd3, 8'd0, 32'h0}, bz);
    check(!bz, "R9", "zero copy idle at once", int'(bz), 0);
    compare_mem("R9");
    do_flush(1'b0);
    check(n_got == 0, "R9", "zero size queued", n_got, 0);

    // R6 wrap
    for (int i = 0; i < 510; i++) run_cmd(mk_fill(1, i % 16, (i / 16) % 16, 1, 1, 32'(i)), bz);
    do_flush(1'b0);
    check(n_got == 510, "R6", "first batch count", n_got, 510);
    bad = 0;
    for (int i = 0; i < 510; i++) if (got_x[i] != i % 16 || got_y[i] != (i / 16) % 16) bad = bad + 1;
    check(bad == 0, "R6", "first batch order mismatches", bad, 0);
    for (int i = 0; i < 5; i++) run_cmd(mk_fill(1, i + 3, 7, 1, 2, 32'(i)), bz);
    do_flush(1'b0);
    check(n_got == 5, "R6", "wrapped batch count", n_got, 5);
    bad = 0;
    for (int i = 0; i < 5; i++) if (got_x[i] != i + 3 || got_y[i] != 7 || got_h[i] != 2) bad = bad + 1;
    check(bad == 0, "R6", "wrapped batch order mismatches", bad, 0);

    finish_run();
  end
endmodule